// File: doc/BRIEF.md
# Two-Half Hamming Parity Generator for a NAND Data Path

This block sits beside the byte-wide data port of a NAND flash controller and builds single-error-correcting Hamming parity for a 512-byte page as the bytes go by. The page is split into a lower and an upper half of 256 bytes each. Each half gets its own 22-bit code: 16 line-parity bits, which locate the failing byte, and 6 column-parity bits, which locate the failing bit inside that byte. The host drives the engine with 8-bit mode commands. One command clears the accumulators. One lets data flow in and parity build up. One turns the data port into a read-back port for the codes. A fourth returns the port to plain data handling and keeps the stored codes.

In use, the host first writes the clear command and performs one throw-away read of the data port. It then enters calculate mode and streams the page in with a byte strobe. Finally it switches to result mode and collects the six code bytes as three 16-bit reads. The bytes of the two halves are interleaved across those three words in a fixed order. Parity is kept inverted, so a fully erased half gives code bytes of all ones.

Top module: `eccGen`

## Requirements
- R1: Writing mode code 0xF4 clears both halves' accumulators and the page byte counter. Whenever the engine is not in result mode, `rdData` reads 0.
- R2: A data-port read (`rdReq`) made while in the 0xF4 state is accepted and has no effect on the parity later produced.
- R3: In mode 0xB4, each byte presented with `dataValid` is accumulated. For index bit k = 0..7 of a byte's position inside its half, line-parity bit 2k+1 collects the XOR of all data bits of bytes whose index has bit k set, and bit 2k collects it for bytes where bit k is clear. Each bit is delivered inverted.
- R4: For k = 0..2, column-parity bit 2k+1 is the XOR of the data bits whose bit position has bit k set, and bit 2k the XOR of those where bit k is clear, over all bytes of the half. The column byte is {~CP5..~CP0, 1, 1}.
- R5: A half made of 256 bytes of 0xFF yields the code bytes 0xFF, 0xFF, 0xFF.
- R6: In mode 0xD4 the three reads return, in order: {lower LP15..8, lower LP7..0}, {upper LP7..0, lower column byte} and {upper column byte, upper LP15..8}. Each `rdReq` moves to the next word, after the third the sequence wraps to the first, and every 0xD4 write restarts at the first word.
- R7: Mode 0x94, or any code other than 0xF4, 0xB4 or 0xD4, stops accumulation. `dataValid` bytes are then ignored, and the stored parity survives until the next 0xF4, so a later 0xD4 reads back the same words.
- R8: The first 256 accumulated bytes after a clear go to the lower half and the next 256 to the upper half. Bytes beyond the 512th are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeWr | input | 1 | Strobe: load `modeIn` as the new mode |
| modeIn | input | 8 | Mode command code |
| dataValid | input | 1 | Strobe: `dataIn` carries a page byte |
| dataIn | input | 8 | Page data byte |
| rdReq | input | 1 | Data-port read strobe; in result mode it advances to the next word |
| rdData | output | 16 | Current result word in result mode, otherwise 0 |

## Verification
The bench goes after the points where an engine can place a bit correctly yet still deliver the wrong word. It uses a single set bit in byte 0 and a single top bit at byte 300. A design that swapped the odd and even members of a parity pair, forgot the inversion, or dropped the two fixed ones of the column byte would show different constants there. A design that split the halves at the wrong byte would move the byte-300 code into the wrong words. It then runs past 512 bytes, reads in the cleared state, sends bytes in data mode and reads a fourth time in result mode. These catch a counter that wraps into the lower half, a dummy read that gets folded into the parity, data mode that still accumulates or clears, and a read pointer that runs off the end instead of wrapping.

// File: rtl/eccGenPkg.sv
package eccGenPkg;

  localparam int HALF_BYTES = 256;
  localparam int IDX_W      = $clog2(HALF_BYTES);
  localparam int LP_W       = 2 * IDX_W;
  localparam int BIT_IDX_W  = 3;
  localparam int CP_W       = 2 * BIT_IDX_W;
  localparam int NUM_WORDS  = 3;
  localparam int PTR_W      = 2;

  localparam logic [7:0] CMD_CLEAR  = 8'hF4;
  localparam logic [7:0] CMD_CALC   = 8'hB4;
  localparam logic [7:0] CMD_RESULT = 8'hD4;

  typedef enum logic [1:0] {
    MODE_IDLE,
    MODE_CLEAR,
    MODE_CALC,
    MODE_RESULT
  } eccMode_e;

  typedef struct packed {
    logic             clearAcc;
    logic             accumEn;
    logic             halfSel;
    logic             resultMode;
    logic [PTR_W-1:0] rdPtr;
  } eccStrb_t;

  // XOR over the bit positions j whose index bit k is set (odd slot) or clear (even slot)
  function automatic logic [CP_W-1:0] colParity(input logic [7:0] d);
    logic [CP_W-1:0] r;
    r = '0;
    for (int k = 0; k < BIT_IDX_W; k++) begin
      for (int j = 0; j < 8; j++) begin
        if (((j >> k) & 1) == 1) r[2*k+1] = r[2*k+1] ^ d[j];
        else                     r[2*k]   = r[2*k]   ^ d[j];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/eccHalf.sv
module eccHalf
  import eccGenPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            clr,
  input  logic            en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]      din,
  output logic [LP_W-1:0] lpAcc,
  output logic [CP_W-1:0] cpAcc
);

  logic            byteOdd;
  logic [LP_W-1:0] lpNext;

  assign byteOdd = ^din;

  always_comb begin
    for (int k = 0; k < IDX_W; k++) begin
      lpNext[2*k+1] = lpAcc[2*k+1] ^ (byteOdd &  idx[k]);
      lpNext[2*k]   = lpAcc[2*k]   ^ (byteOdd & ~idx[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      lpAcc <= '0;
      cpAcc <= '0;
    end else if (en) begin
      lpAcc <= lpNext;
      cpAcc <= cpAcc ^ colParity(din);
    end
  end

endmodule

// File: rtl/eccCtrl.sv
module eccCtrl
  import eccGenPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWr,
  input  logic [7:0]       modeIn,
  input  logic             dataValid,
  input  logic             rdReq,
  output eccStrb_t         strb,
  output logic [IDX_W-1:0] byteIdx
);

  eccMode_e         modeQ;
  logic [IDX_W:0]   byteCnt;
  logic             pageFull;
  logic [PTR_W-1:0] ptrQ;
  logic             accumEn;

  assign accumEn = (modeQ == MODE_CALC) && dataValid && !pageFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_IDLE;
      byteCnt  <= '0;
      pageFull <= 1'b0;
      ptrQ     <= '0;
    end else begin
      if (accumEn) begin
        if (byteCnt == '1) pageFull <= 1'b1;
        byteCnt <= byteCnt + 1'b1;
      end
      if (rdReq && modeQ == MODE_RESULT)
        ptrQ <= (ptrQ == PTR_W'(NUM_WORDS - 1)) ? '0 : ptrQ + 1'b1;
      if (modeWr) begin
        unique case (modeIn)
          CMD_CLEAR: begin
            modeQ    <= MODE_CLEAR;
            byteCnt  <= '0;
            pageFull <= 1'b0;
          end
          CMD_CALC:  modeQ <= MODE_CALC;
          CMD_RESULT: begin
            modeQ <= MODE_RESULT;
            ptrQ  <= '0;
          end
          default:   modeQ <= MODE_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strb.clearAcc   = modeWr && (modeIn == CMD_CLEAR);
    strb.accumEn    = accumEn;
    strb.halfSel    = byteCnt[IDX_W];
    strb.resultMode = (modeQ == MODE_RESULT);
    strb.rdPtr      = ptrQ;
  end

  assign byteIdx = byteCnt[IDX_W-1:0];

endmodule

// File: rtl/eccDatapath.sv
module eccDatapath
  import eccGenPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  eccStrb_t         strb,
  input  logic [IDX_W-1:0] byteIdx,
  input  logic [7:0]       dataIn,
  output logic [15:0]      rdData
);

  logic [LP_W-1:0] lpArr [2];
  logic [CP_W-1:0] cpArr [2];
  logic [LP_W-1:0] lpOut [2];
  logic [7:0]      cpByte [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    eccHalf u_half (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (strb.clearAcc),
      .en    (strb.accumEn && (strb.halfSel == 1'(h))),
      .idx   (byteIdx),
      .din   (dataIn),
      .lpAcc (lpArr[h]),
      .cpAcc (cpArr[h])
    );
    assign lpOut[h]  = ~lpArr[h];
    assign cpByte[h] = {~cpArr[h], 2'b11};
  end

  always_comb begin
    rdData = '0;
    if (strb.resultMode) begin
      unique case (strb.rdPtr)
        2'd0:    rdData = lpOut[0];
        2'd1:    rdData = {lpOut[1][7:0], cpByte[0]};
        default: rdData = {cpByte[1], lpOut[1][15:8]};
      endcase
    end
  end

endmodule

// File: rtl/eccGen.sv
module eccGen
  import eccGenPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWr,
  input  logic [7:0]  modeIn,
  input  logic        dataValid,
  input  logic [7:0]  dataIn,
  input  logic        rdReq,
  output logic [15:0] rdData
);

  eccStrb_t         strb;
  logic [IDX_W-1:0] byteIdx;

  eccCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeWr    (modeWr),
    .modeIn    (modeIn),
    .dataValid (dataValid),
    .rdReq     (rdReq),
    .strb      (strb),
    .byteIdx   (byteIdx)
  );

  eccDatapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .byteIdx (byteIdx),
    .dataIn  (dataIn),
    .rdData  (rdData)
  );

endmodule

// File: rtl/eccGenChk.sv
module eccGenChk
  import eccGenPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        modeWr,
  input logic [7:0]  modeIn,
  input logic        rdReq,
  input logic [15:0] rdData,
  input eccStrb_t    strb
);

  // R1
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && modeIn == CMD_CLEAR) |=> (rdData == 16'h0));

  // R7
  data_mode_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && modeIn == 8'h94) |=> (rdData == 16'h0));

  // R7
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeWr && !rdReq) |=> $stable(rdData));

  // R6
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && strb.resultMode && !modeWr) |=> (strb.rdPtr != $past(strb.rdPtr)));

  // R6
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdPtr != 2'd3);

endmodule

bind eccGen eccGenChk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .modeWr (modeWr),
  .modeIn (modeIn),
  .rdReq  (rdReq),
  .rdData (rdData),
  .strb   (strb)
);

// File: tb/tb_eccGen.sv
`timescale 1ns/1ps
module tb_eccGen;

  logic        clk = 1'b0;
  logic        rstN;
  logic        modeWr;
  logic [7:0]  modeIn;
  logic        dataValid;
  logic [7:0]  dataIn;
  logic        rdReq;
  logic [15:0] rdData;

  int testCnt = 0;
  int failCnt = 0;

  // behavioural model state
  logic [7:0] pageQ[$];
  int         mMode = 0;   // 0 idle, 1 cleared, 2 calc, 3 result
  int         mPtr  = 0;

  always #10 clk = ~clk;

  eccGen dut (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeIn(modeIn),
    .dataValid(dataValid), .dataIn(dataIn), .rdReq(rdReq), .rdData(rdData)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord();
    logic [15:0] lp [2];
    logic [5:0]  cp [2];
    logic [15:0] lo;
    logic [15:0] hi;
    logic [7:0]  cb0;
    logic [7:0]  cb1;
    if (mMode != 3) return 16'h0;
    lp[0] = '0; lp[1] = '0; cp[0] = '0; cp[1] = '0;
    for (int i = 0; i < pageQ.size(); i++) begin
      int h  = i / 256;
      int ix = i % 256;
      for (int b = 0; b < 8; b++) begin
        if (pageQ[i][b]) begin
          for (int k = 0; k < 8; k++)
            if (((ix >> k) & 1) == 1) lp[h][2*k+1] = ~lp[h][2*k+1];
            else                      lp[h][2*k]   = ~lp[h][2*k];
          for (int k = 0; k < 3; k++)
            if (((b >> k) & 1) == 1) cp[h][2*k+1] = ~cp[h][2*k+1];
            else                     cp[h][2*k]   = ~cp[h][2*k];
        end
      end
    end
    lo  = ~lp[0];
    hi  = ~lp[1];
    cb0 = {~cp[0], 2'b11};
    cb1 = {~cp[1], 2'b11};
    if (mPtr == 0) return lo;
    if (mPtr == 1) return {hi[7:0], cb0};
    return {cb1, hi[15:8]};
  endfunction

  // one clock: drive at negedge, update model, compare at next negedge
  task automatic cyc(input bit mw, input logic [7:0] mi, input bit dv,
                     input logic [7:0] di, input bit rr, input string req);
    modeWr = mw; modeIn = mi; dataValid = dv; dataIn = di; rdReq = rr;
    if (dv && mMode == 2 && pageQ.size() < 512) pageQ.push_back(di);
    if (rr && mMode == 3) mPtr = (mPtr + 1) % 3;
    if (mw) begin
      case (mi)
        8'hF4:   begin mMode = 1; pageQ.delete(); end
        8'hB4:   mMode = 2;
        8'hD4:   begin mMode = 3; mPtr = 0; end
        default: mMode = 0;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    modeWr = 0; dataValid = 0; rdReq = 0; modeIn = 8'h00; dataIn = 8'h00;
    check(req, rdData, expWord());
  endtask

  task automatic startPage(input int dummyReads);
    cyc(1, 8'hF4, 0, 0, 0, "R1");
    for (int i = 0; i < dummyReads; i++) cyc(0, 0, 0, 0, 1, "R2");
    cyc(1, 8'hB4, 0, 0, 0, "R3");
  endtask

  task automatic readWords(output logic [15:0] w0, output logic [15:0] w1,
                           output logic [15:0] w2);
    cyc(1, 8'hD4, 0, 0, 0, "R6");
    w0 = rdData;
    cyc(0, 0, 0, 0, 1, "R6");
    w1 = rdData;
    cyc(0, 0, 0, 0, 1, "R6");
    w2 = rdData;
  endtask

  initial begin
    logic [15:0] a0, a1, a2, b0, b1, b2;
    rstN = 0; modeWr = 0; modeIn = 0; dataValid = 0; dataIn = 0; rdReq = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset state", rdData, 16'h0000);

    // R5: erased page
    startPage(1);
    for (int i = 0; i < 512; i++) cyc(0, 0, 1, 8'hFF, 0, "R5");
    readWords(a0, a1, a2);
    check("R5 word0", a0, 16'hFFFF);
    check("R5 word1", a1, 16'hFFFF);
    check("R5 word2", a2, 16'hFFFF);

    // R3/R4: single bit 0 in byte 0; also R2 with several dummy reads
    startPage(3);
    cyc(0, 0, 1, 8'h01, 0, "R3");
    for (int i = 1; i < 512; i++) cyc(0, 0, 1, 8'h00, 0, "R3");
    readWords(a0, a1, a2);
    check("R3 word0", a0, 16'hAAAA);
    check("R4 word1", a1, 16'hFFAB);
    check("R2 word2", a2, 16'hFFFF);
    cyc(0, 0, 0, 0, 1, "R6");
    check("R6 wrap to word0", rdData, 16'hAAAA);

    // R8/R4: top bit of byte 300 lands in the upper half
    startPage(1);
    for (int i = 0; i < 512; i++) cyc(0, 0, 1, (i == 300) ? 8'h80 : 8'h00, 0, "R8");
    readWords(a0, a1, a2);
    check("R8 word0", a0, 16'hFFFF);
    check("R8 word1", a1, 16'h5AFF);
    check("R4 word2", a2, 16'h57A6);

    // R3: random page, then R7: data mode keeps parity and ignores bytes
    startPage(1);
    for (int i = 0; i < 512; i++) cyc(0, 0, 1, 8'($urandom), 0, "R3");
    readWords(a0, a1, a2);
    cyc(1, 8'h94, 0, 0, 0, "R7");
    check("R7 data mode output", rdData, 16'h0000);
    for (int i = 0; i < 20; i++) cyc(0, 0, 1, 8'($urandom), 0, "R7");
    cyc(1, 8'h3C, 0, 0, 0, "R7");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 8'hA5, 0, "R7");
    readWords(b0, b1, b2);
    check("R7 word0 kept", b0, a0);
    check("R7 word1 kept", b1, a1);
    check("R7 word2 kept", b2, a2);

    // R8: bytes past 512 are ignored
    startPage(1);
    for (int i = 0; i < 520; i++) cyc(0, 0, 1, 8'($urandom), 0, "R8");
    readWords(a0, a1, a2);

    // R1: clear then empty calculation gives all ones
    startPage(1);
    readWords(a0, a1, a2);
    check("R1 cleared word0", a0, 16'hFFFF);
    check("R1 cleared word1", a1, 16'hFFFF);
    check("R1 cleared word2", a2, 16'hFFFF);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule